// File: doc/BRIEF.md
# Operand-Waiting Issue Queue with Register Renaming

This block holds a small pool of operation slots in front of one functional unit, together with a per-register table that records which slot will produce each register's next value. At dispatch it takes an opcode, two source register numbers and a destination register number. For each source it either fetches the current register value or records the tag of the slot still computing it. It then renames the destination to the new slot's tag, so a later reader always follows the newest producer. Renaming removes write-after-read and write-after-write conflicts.

Results come back on a shared result bus as a tag and a value. Every waiting slot that needs that tag latches the value. The register whose pending tag matches takes the value and returns to not pending. Once both operands of a slot are present, the slot may issue. One slot issues per cycle, and the oldest ready slot wins. A younger slot that has its operands can therefore overtake an older slot that is still waiting. A flush discards every slot and every pending mark in the table.

Top module: `rs_array`

## Requirements
- R1: After reset no slot is occupied, `disp_ready` is 1, `issue_valid` is 0, no register is pending and every register value is 0.
- R2: A dispatch takes the free slot with the lowest index, and slot k carries tag k+1; tag 0 never names a producer and means "value present". When all slots are occupied, `disp_ready` is 0 and a dispatch request is ignored.
- R3: A source register with no pending producer supplies its stored value at dispatch. A pending source stores the producer's tag instead. The destination register's pending tag becomes the new slot's tag, and this happens after both sources have been looked up.
- R4: A waiting slot whose missing operand tag equals the tag on a valid result bus latches the bus value into that operand. Once both operands are present, the slot issues no earlier than the following cycle.
- R5: When a valid result bus tag equals a register's pending tag, that register takes the bus value and stops being pending. A register whose pending tag differs is not changed.
- R6: If a source's producer broadcasts in the same cycle as the dispatch, the new slot takes the bus value directly and does not wait on that tag.
- R7: A slot with both operands present issues even while an older slot is still waiting for an operand.
- R8: When several slots are ready in one cycle, the one dispatched earliest issues first, whatever its slot index.
- R9: At most one operation issues per cycle, through registered outputs one cycle after it is selected, and each dispatched operation issues exactly once. A slot becomes free only when its own tag appears on the result bus after it has issued.
- R10: A flush empties every slot and clears every pending mark, but keeps register values. Nothing dispatched before the flush issues afterwards, and a later broadcast of an old tag does not change any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all slots and pending marks |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched operation |
| disp_src1 | input | REG_W | First source register number |
| disp_src2 | input | REG_W | Second source register number |
| disp_dst | input | REG_W | Destination register number |
| disp_ready | output | 1 | A free slot exists |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing slot |
| cdb_data | input | DATA_W | Result value |
| issue_valid | output | 1 | An operation is issued this cycle |
| issue_tag | output | TAG_W | Tag of the issued slot |
| issue_op | output | OP_W | Opcode of the issued operation |
| issue_a | output | DATA_W | First operand value |
| issue_b | output | DATA_W | Second operand value |

## Verification
The hardest case to reach is the age ordering: two slots must become ready on the same edge while the older one sits at a higher index than the younger. The stimulus gets there in four steps. It lets one early slot retire, keeps a producer outstanding, dispatches a dependent into a high slot, and then reuses the freed low slot for a second dependent on the same tag. Only then does it broadcast the shared tag. A second hard case is the same-cycle broadcast at dispatch, which is produced by driving the dispatch and the result bus on the same edge. The stimulus also fills every slot and makes one more dispatch attempt, so that any extra issue shows up in the scoreboard.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int NUM_REG = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int REG_W   = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [REG_W-1:0]  rd1_idx,
  input  logic [REG_W-1:0]  rd2_idx,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic [DATA_W-1:0] rd1_val,
  output logic [TAG_W-1:0]  rd2_tag,
  output logic [DATA_W-1:0] rd2_val,
  input  logic              ren_valid,
  input  logic [REG_W-1:0]  ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [TAG_W-1:0]  stat_q [NUM_REG];
  logic [DATA_W-1:0] val_q  [NUM_REG];
  logic [NUM_REG-1:0] hit;

  always_comb begin
    for (int r = 0; r < NUM_REG; r++)
      hit[r] = cdb_valid && (stat_q[r] != '0) && (stat_q[r] == cdb_tag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REG; r++) begin
        stat_q[r] <= '0;
        val_q[r]  <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (flush)
          stat_q[r] <= '0;
        else if (ren_valid && ren_idx == REG_W'(r))
          stat_q[r] <= ren_tag;
        else if (hit[r])
          stat_q[r] <= '0;
        if (hit[r])
          val_q[r] <= cdb_data;
      end
    end
  end

  assign rd1_tag = stat_q[rd1_idx];
  assign rd1_val = val_q[rd1_idx];
  assign rd2_tag = stat_q[rd2_idx];
  assign rd2_val = val_q[rd2_idx];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_chk
    assert_status_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && !flush && !(ren_valid && ren_idx == REG_W'(g))) |=> (stat_q[g] == '0));
    assert_rename_R3: assert property (@(posedge clk) disable iff (rst)
      (ren_valid && !flush && ren_idx == REG_W'(g)) |=> (stat_q[g] == $past(ren_tag)));
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int RANK_W = 2,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qk,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic [RANK_W-1:0] alloc_rank,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              grant,
  input  logic              iss_any,
  input  logic [RANK_W-1:0] iss_rank,
  output logic              busy,
  output logic              waiting,
  output logic              ready,
  output logic [RANK_W-1:0] rank,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  localparam logic [TAG_W-1:0] TAG_V = TAG_W'(MY_TAG);

  slot_state_e       state_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic              hit_j, hit_k, done_hit;

  assign hit_j    = cdb_valid && (qj_q != '0) && (cdb_tag == qj_q);
  assign hit_k    = cdb_valid && (qk_q != '0) && (cdb_tag == qk_q);
  assign done_hit = cdb_valid && (cdb_tag == TAG_V);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q <= SLOT_FREE;
      qj_q    <= '0;
      qk_q    <= '0;
      rank    <= '0;
    end else if (alloc) begin
      state_q <= SLOT_WAIT;
      op      <= alloc_op;
      qj_q    <= alloc_qj;
      vj      <= alloc_vj;
      qk_q    <= alloc_qk;
      vk      <= alloc_vk;
      rank    <= alloc_rank;
    end else begin
      case (state_q)
        SLOT_WAIT: begin
          if (grant) begin
            state_q <= SLOT_EXEC;
          end else begin
            if (hit_j) begin
              qj_q <= '0;
              vj   <= cdb_data;
            end
            if (hit_k) begin
              qk_q <= '0;
              vk   <= cdb_data;
            end
            if (iss_any && rank > iss_rank)
              rank <= rank - RANK_W'(1);
          end
        end
        SLOT_EXEC: if (done_hit) state_q <= SLOT_FREE;
        default: ;
      endcase
    end
  end

  assign busy    = (state_q != SLOT_FREE);
  assign waiting = (state_q == SLOT_WAIT);
  assign ready   = waiting && (qj_q == '0) && (qk_q == '0);

  assert_grant_ready_R9: assert property (@(posedge clk) disable iff (rst)
    grant |-> ready);
  assert_capture_j_R4: assert property (@(posedge clk) disable iff (rst)
    (waiting && hit_j && !flush && !grant) |=> (qj_q == '0));
  assert_capture_k_R4: assert property (@(posedge clk) disable iff (rst)
    (waiting && hit_k && !flush && !grant) |=> (qk_q == '0));
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == SLOT_EXEC && done_hit) |=> !busy);
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int NUM_ENT = 4,
  parameter int RANK_W  = 2,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_ENT-1:0]             ready,
  input  logic [NUM_ENT-1:0][RANK_W-1:0] rank,
  output logic [NUM_ENT-1:0]             grant,
  output logic                           any,
  output logic [IDX_W-1:0]               sel_idx,
  output logic [RANK_W-1:0]              sel_rank
);
  always_comb begin
    any      = 1'b0;
    sel_idx  = '0;
    sel_rank = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ready[i] && (!any || rank[i] < sel_rank)) begin
        any      = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_rank = rank[i];
      end
    end
    grant = '0;
    if (any) grant[sel_idx] = 1'b1;
  end
endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 4,
  parameter int NUM_REG = 8,
  parameter int REG_W   = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              disp_valid,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [REG_W-1:0]  disp_src1,
  input  logic [REG_W-1:0]  disp_src2,
  input  logic [REG_W-1:0]  disp_dst,
  output logic              disp_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              issue_valid,
  output logic [TAG_W-1:0]  issue_tag,
  output logic [OP_W-1:0]   issue_op,
  output logic [DATA_W-1:0] issue_a,
  output logic [DATA_W-1:0] issue_b
);
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int RANK_W = IDX_W;

  logic [NUM_ENT-1:0]             busy, waiting, ready, grant, sel_grant;
  logic [NUM_ENT-1:0][RANK_W-1:0] rank;
  logic [OP_W-1:0]                s_op [NUM_ENT];
  logic [DATA_W-1:0]              s_vj [NUM_ENT];
  logic [DATA_W-1:0]              s_vk [NUM_ENT];
  logic                           sel_any, iss_fire, have_free, disp_fire;
  logic [IDX_W-1:0]               sel_idx, alloc_idx;
  logic [RANK_W-1:0]              sel_rank, new_rank;
  logic [TAG_W-1:0]               new_tag, rd1_tag, rd2_tag, src1_q, src2_q;
  logic [DATA_W-1:0]              rd1_val, rd2_val, src1_v, src2_v;

  always_comb begin
    have_free = 1'b0;
    alloc_idx = '0;
    for (int i = NUM_ENT-1; i >= 0; i--) begin
      if (!busy[i]) begin
        have_free = 1'b1;
        alloc_idx = IDX_W'(i);
      end
    end
  end

  assign disp_ready = have_free;
  assign disp_fire  = disp_valid && have_free && !flush;
  assign new_tag    = TAG_W'(alloc_idx) + TAG_W'(1);
  assign iss_fire   = sel_any && !flush;
  assign grant      = sel_grant & {NUM_ENT{!flush}};

  always_comb begin
    new_rank = '0;
    for (int i = 0; i < NUM_ENT; i++)
      new_rank = new_rank + RANK_W'(waiting[i] && !grant[i]);
  end

  rs_regstat #(.NUM_REG(NUM_REG), .DATA_W(DATA_W), .TAG_W(TAG_W), .REG_W(REG_W)) u_regstat (
    .clk(clk), .rst(rst), .flush(flush),
    .rd1_idx(disp_src1), .rd2_idx(disp_src2),
    .rd1_tag(rd1_tag), .rd1_val(rd1_val), .rd2_tag(rd2_tag), .rd2_val(rd2_val),
    .ren_valid(disp_fire), .ren_idx(disp_dst), .ren_tag(new_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  // A producer broadcasting in the dispatch cycle is forwarded straight in.
  always_comb begin
    src1_q = rd1_tag;
    src1_v = rd1_val;
    if (rd1_tag != '0 && cdb_valid && cdb_tag == rd1_tag) begin
      src1_q = '0;
      src1_v = cdb_data;
    end
    src2_q = rd2_tag;
    src2_v = rd2_val;
    if (rd2_tag != '0 && cdb_valid && cdb_tag == rd2_tag) begin
      src2_q = '0;
      src2_v = cdb_data;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    rs_slot #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .RANK_W(RANK_W), .MY_TAG(g + 1)) u_slot (
      .clk(clk), .rst(rst), .flush(flush),
      .alloc(disp_fire && alloc_idx == IDX_W'(g)),
      .alloc_op(disp_op), .alloc_qj(src1_q), .alloc_vj(src1_v),
      .alloc_qk(src2_q), .alloc_vk(src2_v), .alloc_rank(new_rank),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .grant(grant[g]), .iss_any(iss_fire), .iss_rank(sel_rank),
      .busy(busy[g]), .waiting(waiting[g]), .ready(ready[g]), .rank(rank[g]),
      .op(s_op[g]), .vj(s_vj[g]), .vk(s_vk[g])
    );
    assert_oldest_R8: assert property (@(posedge clk) disable iff (rst)
      (sel_any && ready[g]) |-> (sel_rank <= rank[g]));
  end

  rs_select #(.NUM_ENT(NUM_ENT), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_select (
    .ready(ready), .rank(rank), .grant(sel_grant), .any(sel_any),
    .sel_idx(sel_idx), .sel_rank(sel_rank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tag   <= '0;
      issue_op    <= '0;
      issue_a     <= '0;
      issue_b     <= '0;
    end else begin
      issue_valid <= iss_fire;
      if (iss_fire) begin
        issue_tag <= TAG_W'(sel_idx) + TAG_W'(1);
        issue_op  <= s_op[sel_idx];
        issue_a   <= s_vj[sel_idx];
        issue_b   <= s_vk[sel_idx];
      end
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (disp_ready && !issue_valid));
  assert_tag_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_tag != '0));
endmodule

// File: tb/sim_rs_array.sv
module sim_rs_array;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4, DATA_W = 32, OP_W = 4, REG_W = 3;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic disp_valid = 1'b0;
  logic [OP_W-1:0] disp_op = '0;
  logic [REG_W-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic disp_ready;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [DATA_W-1:0] cdb_data = '0;
  logic issue_valid;
  logic [TAG_W-1:0] issue_tag;
  logic [OP_W-1:0] issue_op;
  logic [DATA_W-1:0] issue_a, issue_b;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [TAG_W+OP_W+2*DATA_W-1:0] exp_q [$];
  string req_q [$];

  rs_array u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_src1(disp_src1),
    .disp_src2(disp_src2), .disp_dst(disp_dst), .disp_ready(disp_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic expect_iss(input int tag, input int op, input int a, input int b, input string req);
    exp_q.push_back({TAG_W'(tag), OP_W'(op), DATA_W'(a), DATA_W'(b)});
    req_q.push_back(req);
  endtask

  task automatic disp(input int op, input int s1, input int s2, input int d);
    @(negedge clk);
    disp_valid = 1'b1; disp_op = OP_W'(op);
    disp_src1 = REG_W'(s1); disp_src2 = REG_W'(s2); disp_dst = REG_W'(d);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input int tag, input int val);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = TAG_W'(tag); cdb_data = DATA_W'(val);
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_reg(input int r, input int val);
    expect_iss(1, 0, 0, 0, "R1 zero regs");
    disp(0, 0, 0, r);
    idle(1);
    bcast(1, val);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every issue.
  always @(posedge clk) begin
    #1;
    if (!rst && issue_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9: unexpected issue tag=%0d op=%0d a=%0h b=%0h, expected none",
                 issue_tag, issue_op, issue_a, issue_b);
      end else begin
        logic [TAG_W+OP_W+2*DATA_W-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({issue_tag, issue_op, issue_a, issue_b} == e, r,
              longint'({issue_tag, issue_op, issue_a, issue_b}), longint'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 3000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 3000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(disp_ready == 1'b1, "R1 disp_ready", disp_ready, 1);
    check(issue_valid == 1'b0, "R1 issue_valid", issue_valid, 0);

    load_reg(1, 100);
    load_reg(2, 7);

    // R3 R4 R7: dependent waits, independent overtakes
    expect_iss(1, 1, 100, 7, "R3 ready sources");
    disp(1, 1, 2, 3);
    disp(2, 3, 1, 4);
    expect_iss(3, 3, 7, 7, "R7 overtake");
    disp(3, 2, 2, 5);
    idle(1);
    expect_iss(2, 2, 93, 100, "R4 wakeup");
    bcast(1, 93);
    idle(2);
    bcast(3, 'h55);
    bcast(2, 'h66);
    expect_iss(1, 0, 93, 100, "R5 reg written");
    disp(0, 3, 1, 6);
    idle(1);
    bcast(1, 0);

    // R8: older slot at higher index wins
    expect_iss(1, 0, 100, 7, "R8 setup A");
    disp(0, 1, 2, 6);
    expect_iss(2, 1, 7, 7, "R8 setup B");
    disp(1, 2, 2, 7);
    disp(2, 7, 1, 3);
    idle(1);
    bcast(1, 11);
    disp(3, 2, 7, 4);
    expect_iss(3, 2, 22, 100, "R8 oldest first");
    expect_iss(1, 3, 7, 22, "R8 younger second");
    bcast(2, 22);
    idle(2);
    bcast(3, 'h33);
    bcast(1, 'h44);

    // R6: broadcast in the dispatch cycle
    expect_iss(1, 0, 100, 100, "R6 producer");
    disp(0, 1, 1, 5);
    idle(1);
    expect_iss(2, 1, 77, 7, "R6 forward");
    @(negedge clk);
    disp_valid = 1'b1; disp_op = 4'd1; disp_src1 = 3'd5; disp_src2 = 3'd2; disp_dst = 3'd6;
    cdb_valid = 1'b1; cdb_tag = 4'd1; cdb_data = 77;
    @(negedge clk);
    disp_valid = 1'b0; cdb_valid = 1'b0;
    idle(1);
    bcast(2, 'h88);

    // R2: full pool
    expect_iss(1, 0, 100, 7, "R2 producer");
    disp(0, 1, 2, 3);
    idle(1);
    disp(1, 3, 1, 0);
    disp(2, 3, 2, 5);
    disp(3, 1, 3, 6);
    check(disp_ready == 1'b0, "R2 full", disp_ready, 0);
    disp(0, 1, 1, 7);
    check(disp_ready == 1'b0, "R2 still full", disp_ready, 0);
    expect_iss(2, 1, 5, 100, "R2 wake 1");
    expect_iss(3, 2, 5, 7, "R2 wake 2");
    expect_iss(4, 3, 100, 5, "R2 wake 3");
    bcast(1, 5);
    idle(4);

    // R10: flush
    disp(2, 6, 6, 7);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(disp_ready == 1'b1, "R10 slots empty", disp_ready, 1);
    bcast(4, 'h99);
    idle(2);
    expect_iss(1, 3, 'h88, 22, "R10 status cleared");
    disp(3, 6, 7, 1);
    idle(3);
    check(exp_q.size() == 0, "R9 all issued", exp_q.size(), 0);
    finish_run();
  end
endmodule